// File: doc/BRIEF.md
# In-Order Destination Scoreboard

This block records the destination registers of every instruction that has left the decode stage and has not yet committed. The pipeline uses it to detect read-after-write hazards. Each dispatched instruction pushes one entry onto an ordered queue. The entry holds a destination register index and a flag that says whether the index is meaningful. Every commit pops the oldest entry. Instructions commit in order, so pushes and pops stay paired one to one. An instruction that writes no register still takes an entry, marked as having no destination.

Two search ports are evaluated combinationally in the same cycle, one for each source operand of the instruction being decoded. A port raises its hazard flag when its source is valid and at least one occupied entry holds a valid destination with the same index. The flag therefore stays high until every older writer of that register has committed. Searches look only at the queue contents latched at the last clock edge. A full flag tells the dispatch logic that no slot is free. Stall control, operand bypass and register file access are the job of the surrounding pipeline.

Top module: `in_order_dst_scoreboard`

## Requirements
- R1: After reset the queue is empty: full is low, and both hazard flags are low for any source index.
- R2: An insert request made while full is low adds one entry at the young end of the queue. That entry takes part in searches from the cycle after the clock edge that accepts it.
- R3: A port reports a hazard only when its source is valid, an occupied entry holds a valid destination, and the two indices are equal. An entry inserted with its destination flag low occupies a slot but never matches.
- R4: The two search ports work in the same cycle and independently of each other. Each flag depends only on its own source fields.
- R5: A hazard persists while any occupied entry matches. Two in-flight writers of one register need two removes before the flag drops.
- R6: A remove request retires the oldest occupied entry. A remove request while the queue is empty is ignored and leaves the occupancy at zero.
- R7: Full is high exactly when all DEPTH slots are occupied. An insert request while full is high is dropped and leaves no entry behind.
- R8: An insert and a remove in the same cycle retire the oldest entry and append the new one, so occupancy is unchanged. When the queue is full, that remove still happens and that insert is dropped.
- R9: Searches compare against the entries that existed before the current cycle's operations. An entry being inserted is not yet visible, and an entry being removed is still visible during that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_en | input | 1 | Insert request for a dispatched instruction |
| ins_dst_vld | input | 1 | The inserted instruction writes a register |
| ins_dst_idx | input | IDX_W | Destination register index of the inserted instruction |
| rem_en | input | 1 | Remove the oldest entry at commit |
| src_a_vld | input | 1 | First source operand is a register read |
| src_a_idx | input | IDX_W | First source register index |
| src_b_vld | input | 1 | Second source operand is a register read |
| src_b_idx | input | IDX_W | Second source register index |
| haz_a | output | 1 | First source matches an in-flight destination |
| haz_b | output | 1 | Second source matches an in-flight destination |
| full | output | 1 | All slots are occupied |

## Verification
The hazard flags are combinational over state that updates on the rising edge. A search is therefore answered in the cycle it is presented. An insert or remove affects the flags and full only from the cycle after the edge that accepts it. The bench changes inputs on the falling edge and samples one time unit later. This lets it see both the pre-edge view, which checks that same-cycle inserts are hidden and same-cycle removes are still visible, and the post-edge view after each operation. Requests that must be ignored, such as a remove when empty or an insert when full, are shown to have no effect through later searches and the full flag.

// File: rtl/sb_pkg.sv
package sb_pkg;

   typedef enum logic [1:0] {
      Q_HOLD = 2'b00,
      Q_POP  = 2'b01,
      Q_PUSH = 2'b10,
      Q_SWAP = 2'b11
   } q_op_e;

   function automatic q_op_e q_op(input logic push_ok, input logic pop_ok);
      return q_op_e'({push_ok, pop_ok});
   endfunction

endpackage

// File: rtl/sb_queue.sv
module sb_queue
   import sb_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int IDX_W = 5,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   push,
   input  logic                   push_vld,
   input  logic [IDX_W-1:0]       push_idx,
   input  logic                   pop,
   output logic [DEPTH-1:0]       live_mask,
   output logic [DEPTH*IDX_W-1:0] flat_idx,
   output logic [CNT_W-1:0]       count,
   output logic                   is_full
);

   logic [PTR_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] cnt_q;
   logic             push_ok, pop_ok;
   logic             ent_vld_q [DEPTH];
   logic [IDX_W-1:0] ent_idx_q [DEPTH];
   q_op_e            op;

   function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign is_full = (cnt_q == CNT_W'(DEPTH));
   assign push_ok = push && !is_full;
   assign pop_ok  = pop && (cnt_q != '0);
   assign op      = q_op(push_ok, pop_ok);
   assign count   = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         case (op)
            Q_PUSH: begin
               tail_q <= ptr_inc(tail_q);
               cnt_q  <= cnt_q + 1'b1;
            end
            Q_POP: begin
               head_q <= ptr_inc(head_q);
               cnt_q  <= cnt_q - 1'b1;
            end
            Q_SWAP: begin
               tail_q <= ptr_inc(tail_q);
               head_q <= ptr_inc(head_q);
            end
            default: ;
         endcase
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent_vld_q[i] <= 1'b0;
         else if (push_ok && tail_q == PTR_W'(i))
            ent_vld_q[i] <= push_vld;
      end

      always_ff @(posedge clk) begin
         if (push_ok && tail_q == PTR_W'(i))
            ent_idx_q[i] <= push_idx;
      end

      always_comb begin
         int off;
         if (i >= int'(head_q))
            off = i - int'(head_q);
         else
            off = i + DEPTH - int'(head_q);
         live_mask[i] = ent_vld_q[i] && (off < int'(cnt_q));
      end

      assign flat_idx[i*IDX_W +: IDX_W] = ent_idx_q[i];
   end

endmodule

// File: rtl/sb_match_port.sv
module sb_match_port #(
   parameter int DEPTH = 4,
   parameter int IDX_W = 5
) (
   input  logic                   src_vld,
   input  logic [IDX_W-1:0]       src_idx,
   input  logic [DEPTH-1:0]       live_mask,
   input  logic [DEPTH*IDX_W-1:0] flat_idx,
   output logic                   hit
);

   logic [DEPTH-1:0] eq;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign eq[i] = live_mask[i] && (flat_idx[i*IDX_W +: IDX_W] == src_idx);
   end

   assign hit = src_vld && (|eq);

endmodule

// File: rtl/in_order_dst_scoreboard.sv
module in_order_dst_scoreboard #(
   parameter int DEPTH = 4,
   parameter int IDX_W = 5,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int N_SRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_en,
   input  logic             ins_dst_vld,
   input  logic [IDX_W-1:0] ins_dst_idx,
   input  logic             rem_en,
   input  logic             src_a_vld,
   input  logic [IDX_W-1:0] src_a_idx,
   input  logic             src_b_vld,
   input  logic [IDX_W-1:0] src_b_idx,
   output logic             haz_a,
   output logic             haz_b,
   output logic             full
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("scoreboard DEPTH must be at least 2");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("scoreboard IDX_W must be at least 1");
   end

   logic [DEPTH-1:0]       live_mask;
   logic [DEPTH*IDX_W-1:0] flat_idx;
   logic [CNT_W-1:0]       occ;
   logic                   src_vld [N_SRC];
   logic [IDX_W-1:0]       src_idx [N_SRC];
   logic                   hit     [N_SRC];

   sb_queue #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (ins_en),
      .push_vld  (ins_dst_vld),
      .push_idx  (ins_dst_idx),
      .pop       (rem_en),
      .live_mask (live_mask),
      .flat_idx  (flat_idx),
      .count     (occ),
      .is_full   (full)
   );

   assign src_vld[0] = src_a_vld;
   assign src_idx[0] = src_a_idx;
   assign src_vld[1] = src_b_vld;
   assign src_idx[1] = src_b_idx;

   for (genvar p = 0; p < N_SRC; p++) begin : g_port
      sb_match_port #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_m (
         .src_vld   (src_vld[p]),
         .src_idx   (src_idx[p]),
         .live_mask (live_mask),
         .flat_idx  (flat_idx),
         .hit       (hit[p])
      );
   end

   assign haz_a = hit[0];
   assign haz_b = hit[1];

endmodule

// File: rtl/sb_chk.sv
module sb_chk #(
   parameter int DEPTH = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ins_en,
   input logic             rem_en,
   input logic             src_a_vld,
   input logic             src_b_vld,
   input logic             haz_a,
   input logic             haz_b,
   input logic             full,
   input logic [CNT_W-1:0] occ
);

   // R3
   a_src_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !src_a_vld |-> !haz_a);

   // R3
   b_src_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !src_b_vld |-> !haz_b);

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH));

   // R7
   full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && ins_en && !rem_en) |=> full);

   // R2
   insert_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && !full && !rem_en) |=> occ == $past(occ) + 1'b1);

   // R6
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_en && !ins_en && occ == '0) |=> occ == '0);

   // R8
   swap_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && rem_en && occ != '0 && !full) |=> occ == $past(occ));

endmodule

bind in_order_dst_scoreboard sb_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ins_en    (ins_en),
   .rem_en    (rem_en),
   .src_a_vld (src_a_vld),
   .src_b_vld (src_b_vld),
   .haz_a     (haz_a),
   .haz_b     (haz_b),
   .full      (full),
   .occ       (occ)
);

// File: tb/sim_in_order_dst_scoreboard.sv
module sim_in_order_dst_scoreboard;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 4;
   localparam int IDX_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ins_en = 1'b0;
   logic             ins_dst_vld = 1'b0;
   logic [IDX_W-1:0] ins_dst_idx = '0;
   logic             rem_en = 1'b0;
   logic             src_a_vld = 1'b0;
   logic [IDX_W-1:0] src_a_idx = '0;
   logic             src_b_vld = 1'b0;
   logic [IDX_W-1:0] src_b_idx = '0;
   logic             haz_a, haz_b, full;

   int n_checks = 0;
   int n_errors = 0;
   bit reported = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   in_order_dst_scoreboard #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u0 (
      .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .ins_dst_vld(ins_dst_vld),
      .ins_dst_idx(ins_dst_idx), .rem_en(rem_en), .src_a_vld(src_a_vld),
      .src_a_idx(src_a_idx), .src_b_vld(src_b_vld), .src_b_idx(src_b_idx),
      .haz_a(haz_a), .haz_b(haz_b), .full(full)
   );

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      ins_en = 1'b0;
      rem_en = 1'b0;
   endtask

   task automatic probe(input logic av, input int ai, input logic bv, input int bi);
      src_a_vld = av;
      src_a_idx = IDX_W'(ai);
      src_b_vld = bv;
      src_b_idx = IDX_W'(bi);
      #1;
   endtask

   task automatic put(input logic v, input int idx);
      ins_en = 1'b1;
      ins_dst_vld = v;
      ins_dst_idx = IDX_W'(idx);
      tick();
   endtask

   task automatic drain(input int n);
      for (int k = 0; k < n; k++) begin
         rem_en = 1'b1;
         tick();
      end
   endtask

   task automatic t_reset();
      probe(1'b1, 3, 1'b1, 0);
      check("R1 haz_a after reset", haz_a, 0);
      check("R1 haz_b after reset", haz_b, 0);
      check("R1 full after reset", full, 0);
   endtask

   task automatic t_basic();
      ins_en = 1'b1; ins_dst_vld = 1'b1; ins_dst_idx = 5'd7;
      probe(1'b1, 7, 1'b0, 0);
      check("R9 insert hidden same cycle", haz_a, 0);
      tick();
      probe(1'b1, 7, 1'b0, 0);
      check("R2 inserted entry visible", haz_a, 1);
      probe(1'b0, 7, 1'b0, 7);
      check("R3 invalid source a", haz_a, 0);
      check("R3 invalid source b", haz_b, 0);
      probe(1'b1, 8, 1'b1, 7);
      check("R4 port a other index", haz_a, 0);
      check("R4 port b matching index", haz_b, 1);
      drain(1);
      probe(1'b1, 7, 1'b1, 7);
      check("R6 removed entry gone", haz_a, 0);
   endtask

   task automatic t_nodst();
      put(1'b0, 9);
      probe(1'b1, 9, 1'b1, 0);
      check("R3 no-destination entry never matches", haz_a, 0);
      put(1'b1, 1);
      put(1'b1, 2);
      put(1'b1, 3);
      probe(1'b1, 2, 1'b0, 0);
      check("R7 no-destination entry holds a slot", full, 1);
      check("R2 third entry visible", haz_a, 1);
      drain(4);
      check("R6 drained not full", full, 0);
   endtask

   task automatic t_multi();
      put(1'b1, 5);
      put(1'b1, 5);
      drain(1);
      probe(1'b1, 5, 1'b1, 5);
      check("R5 second writer keeps hazard", haz_a, 1);
      drain(1);
      probe(1'b1, 5, 1'b1, 5);
      check("R5 hazard clears after both writers", haz_b, 0);
   endtask

   task automatic t_oldest();
      put(1'b1, 10);
      put(1'b1, 11);
      drain(1);
      probe(1'b1, 10, 1'b1, 11);
      check("R6 oldest entry retired", haz_a, 0);
      check("R6 younger entry remains", haz_b, 1);
      drain(1);
   endtask

   task automatic t_full();
      for (int k = 1; k <= DEPTH; k++) put(1'b1, k);
      probe(1'b1, 20, 1'b0, 0);
      check("R7 full after DEPTH inserts", full, 1);
      put(1'b1, 20);
      probe(1'b1, 20, 1'b0, 0);
      check("R7 insert while full dropped", haz_a, 0);
      check("R7 still full", full, 1);
      drain(DEPTH);
      probe(1'b1, 20, 1'b0, 0);
      check("R7 dropped entry never appears", haz_a, 0);
      drain(1);
      probe(1'b0, 0, 1'b0, 0);
      check("R6 remove on empty keeps not full", full, 0);
      put(1'b1, 6);
      probe(1'b1, 6, 1'b0, 0);
      check("R6 insert after empty remove visible", haz_a, 1);
      drain(1);
      probe(1'b1, 6, 1'b0, 0);
      check("R6 occupancy stayed at zero", haz_a, 0);
   endtask

   task automatic t_both();
      put(1'b1, 12);
      ins_en = 1'b1; ins_dst_vld = 1'b1; ins_dst_idx = 5'd13; rem_en = 1'b1;
      probe(1'b1, 12, 1'b1, 13);
      check("R9 removed entry visible same cycle", haz_a, 1);
      check("R9 inserted entry hidden same cycle", haz_b, 0);
      tick();
      probe(1'b1, 12, 1'b1, 13);
      check("R8 swap retired oldest", haz_a, 0);
      check("R8 swap appended new", haz_b, 1);
      check("R8 swap not full", full, 0);
      put(1'b1, 14);
      put(1'b1, 15);
      put(1'b1, 16);
      ins_en = 1'b1; ins_dst_vld = 1'b1; ins_dst_idx = 5'd25; rem_en = 1'b1;
      tick();
      probe(1'b1, 25, 1'b1, 13);
      check("R8 full swap drops insert", haz_a, 0);
      check("R8 full swap removes oldest", haz_b, 0);
      check("R8 full swap leaves a free slot", full, 0);
      drain(3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_nodst();
      t_multi();
      t_oldest();
      t_full();
      t_both();
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      report();
   end

endmodule